// File: doc/BRIEF.md
# Stream-fed serial line transmitter

This block takes data words from a valid/ready stream and sends each one on a single serial output. A frame is one low start bit, then the data bits with the least significant bit first, then one high stop bit. The line rests high between frames. The word is latched when the handshake completes. The source is then held off until the stop bit has finished, so no storage is needed beyond one shift register.

Bit timing comes from a prescale input that is read every cycle. One bit lasts eight times the prescale value in clock cycles, so prescale is set to the clock frequency divided by eight times the baud rate. The value is not captured at the start of a frame. If it changes during a frame, the timing of the bit in progress changes at once. A busy output marks the whole span of a frame.

Top module: `uart_serializer`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `s_ready` is 1.
- R2: A word is taken only on a clock edge where `s_valid` and `s_ready` are both 1. A word offered while `busy` is 1 is not taken and does not alter the line, even if `s_valid` stays high for many cycles.
- R3: The start bit drives `txd` to 0 for 8×P cycles, where P is `prescale`. A prescale of 0 is treated as 1, giving 8 cycles.
- R4: After the start bit, the DATA_W data bits are sent least significant bit first. Each bit holds `txd` for 8×P cycles.
- R5: After the last data bit, `txd` is 1 for one 8×P stop bit. The line then stays 1 with `busy` at 0 and `s_ready` at 1 until the next word is taken.
- R6: From the clock edge that takes a word until the stop bit ends, `busy` is 1 and `s_ready` is 0. Both outputs change in the first cycle after that edge.
- R7: Changes on `s_data` after a word is taken have no effect on the frame being sent.
- R8: `prescale` is read every cycle. A bit ends at the first edge where the number of cycles already spent in it reaches 8×P minus one, using the current value of P. If P drops below the count already reached, the bit ends at the next edge.
- R9: If a word is already waiting with `s_valid` high when the stop bit ends, it is taken on the next edge. The two frames are then separated by exactly one idle-high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale | input | PRESCALE_W | Bit period in units of 8 clock cycles |
| s_data | input | DATA_W | Word offered by the source |
| s_valid | input | 1 | Source has a word |
| s_ready | output | 1 | Transmitter can take a word |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in flight |

## Verification
The timing reference is the handshake edge. Every output settles one cycle after it: the start bit appears, and `busy` and `s_ready` change. Bit k of the frame then occupies cycles k·8P through k·8P+8P−1, counted from that edge. `s_ready` returns at cycle 10·8P.

The bench drives inputs and samples outputs on the falling edge. It keeps a sample index from the handshake and compares every cycle of every bit against the bit expected at that index. It also checks the idle state at exactly the cycle where the frame should end. For the live-prescale case, the shortened first bit is worked out from the counter value at the cycle the prescale drops.

// File: rtl/uart_ser_pkg.sv
package uart_ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // Cycles per bit for a given prescale; a zero prescale behaves as one.
  function automatic int unsigned bit_cycles(input int unsigned p);
    return (p == 0) ? 8 : p * 8;
  endfunction
endpackage

// File: rtl/uart_ser_bit_timer.sv
module uart_ser_bit_timer #(
  parameter int PRESCALE_W = 16,
  localparam int CNT_W = PRESCALE_W + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [PRESCALE_W-1:0] prescale,
  output logic                  bit_done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // Live period: no capture, so a new prescale acts on the current bit.
  always_comb begin
    if (prescale == '0) limit = CNT_W'(8);
    else                limit = {prescale, 3'b000};
  end

  // ">=" so that a smaller prescale mid-bit ends the bit at once instead of wrapping.
  assign bit_done = run && (cnt >= limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (!run || bit_done)  cnt <= '0;
    else                        cnt <= cnt + CNT_W'(1);
  end

  AST_TIMER_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    bit_done |=> (cnt == '0)); // R8

  AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (run && $stable(prescale)) |-> (cnt < limit)); // R8
endmodule

// File: rtl/uart_ser_shifter.sv
module uart_ser_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              lsb
);
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '0;
    else if (load)  shreg <= din;
    else if (shift) shreg <= shreg >> 1;
  end

  assign lsb = shreg[0];

  AST_SHREG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(shreg)); // R7
endmodule

// File: rtl/uart_ser_ctrl.sv
module uart_ser_ctrl
  import uart_ser_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic s_valid,
  input  logic bit_done,
  input  logic lsb,
  output logic s_ready,
  output logic busy,
  output logic txd,
  output logic run,
  output logic load,
  output logic shift
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e        state;
  logic [IDX_W-1:0] bit_idx;
  logic             accept;

  assign accept = s_valid && s_ready;
  assign load   = accept;
  assign run    = (state != ST_IDLE);
  assign shift  = bit_done &&
                  ((state == ST_START) || ((state == ST_DATA) && (bit_idx != LAST_IDX)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      s_ready <= 1'b1;
      busy    <= 1'b0;
      txd     <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_START;
            s_ready <= 1'b0;
            busy    <= 1'b1;
            txd     <= 1'b0;
          end
        end
        ST_START: begin
          if (bit_done) begin
            state   <= ST_DATA;
            bit_idx <= '0;
            txd     <= lsb;
          end
        end
        ST_DATA: begin
          if (bit_done) begin
            if (bit_idx == LAST_IDX) begin
              state <= ST_STOP;
              txd   <= 1'b1;
            end else begin
              bit_idx <= bit_idx + IDX_W'(1);
              txd     <= lsb;
            end
          end
        end
        ST_STOP: begin
          if (bit_done) begin
            state   <= ST_IDLE;
            s_ready <= 1'b1;
            busy    <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!txd && busy && !s_ready)); // R6

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !s_ready); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> txd); // R5

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> !txd); // R3

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP && bit_done) |=> (s_ready && !busy && txd)); // R5

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= LAST_IDX); // R4
endmodule

// File: rtl/uart_serializer.sv
module uart_serializer #(
  parameter int DATA_W     = 8,
  parameter int PRESCALE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic [DATA_W-1:0]     s_data,
  input  logic                  s_valid,
  output logic                  s_ready,
  output logic                  txd,
  output logic                  busy
);
  logic run;
  logic bit_done;
  logic load;
  logic shift;
  logic lsb;

  uart_ser_bit_timer #(.PRESCALE_W(PRESCALE_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .prescale (prescale),
    .bit_done (bit_done)
  );

  uart_ser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .shift (shift),
    .din   (s_data),
    .lsb   (lsb)
  );

  uart_ser_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .bit_done (bit_done),
    .lsb      (lsb),
    .s_ready  (s_ready),
    .busy     (busy),
    .txd      (txd),
    .run      (run),
    .load     (load),
    .shift    (shift)
  );
endmodule

// File: tb/uart_serializer_bench.sv
module uart_serializer_bench;
  localparam int W  = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] prescale = 16'd1;
  logic [W-1:0]  s_data = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic          txd;
  logic          busy;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  uart_serializer #(.DATA_W(W), .PRESCALE_W(PW)) u_uart_serializer (
    .clk(clk), .rst(rst), .prescale(prescale), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .txd(txd), .busy(busy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sample {s_ready,busy,txd} against the idle pattern 3'b101.
  task automatic check_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk({s_ready, busy, txd} == 3'b101, req, "idle line", int'({s_ready, busy, txd}), 5);
      @(negedge clk);
    end
  endtask

  // Offer d with s_ready high, then check every cycle of the frame.
  // first_len: cycles of the start bit; rest_len: cycles of every later bit.
  task automatic run_frame(input logic [W-1:0] d, input int first_len, input int rest_len,
                           input int dist_from, input int dist_to, input logic [W-1:0] dist_data,
                           input int chg_at, input logic [PW-1:0] chg_val, input string req);
    int total;
    int first_bad [W+2];
    int bad_val [W+2];
    int exp_val [W+2];
    bit disturbing;
    total = first_len + (W + 1) * rest_len;
    for (int j = 0; j < W + 2; j++) first_bad[j] = -1;
    disturbing = 1'b0;
    s_data  = d;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    // R6: one cycle after the taking edge.
    chk(busy && !s_ready, "R6", "busy/ready after take", int'({busy, s_ready}), 2);
    for (int n = 0; n < total; n++) begin
      int j;
      logic e;
      j = (n < first_len) ? 0 : 1 + (n - first_len) / rest_len;
      e = (j == 0) ? 1'b0 : (j <= W) ? d[j-1] : 1'b1;
      if (first_bad[j] < 0 && ({s_ready, busy, txd} !== {2'b01, e})) begin
        first_bad[j] = n;
        bad_val[j]   = int'({s_ready, busy, txd});
        exp_val[j]   = int'({2'b01, e});
      end
      if (n == dist_from) disturbing = 1'b1;
      if (n == dist_to) begin
        disturbing = 1'b0;
        s_valid = 1'b0;
      end
      if (disturbing) begin
        s_valid = 1'b1;
        s_data  = dist_data;
      end else begin
        s_data = W'(n) ^ 8'h5A; // R7: scramble the bus while busy
      end
      if (n == chg_at) prescale = chg_val;
      @(negedge clk);
    end
    for (int j = 0; j < W + 2; j++)
      chk(first_bad[j] < 0, req, $sformatf("frame bit %0d", j),
          (first_bad[j] < 0) ? 0 : bad_val[j], (first_bad[j] < 0) ? 0 : exp_val[j]);
  endtask

  task automatic t_reset();
    chk({s_ready, busy, txd} == 3'b101, "R1", "reset state", int'({s_ready, busy, txd}), 5);
  endtask

  task automatic t_basic();
    prescale = 16'd1;
    run_frame(8'hA5, 8, 8, -1, -1, '0, -1, '0, "R4");  // R3 R4 timing at P=1
    check_idle("R5", 12);
  endtask

  task automatic t_ignore_busy();
    prescale = 16'd2;
    run_frame(8'h3C, 16, 16, 5, 60, 8'hC3, -1, '0, "R2,R7");
    check_idle("R2", 40);
  endtask

  task automatic t_zero_prescale();
    prescale = 16'd0;
    run_frame(8'h81, 8, 8, -1, -1, '0, -1, '0, "R3");
    check_idle("R3", 6);
  endtask

  task automatic t_back_to_back();
    prescale = 16'd1;
    run_frame(8'h0F, 8, 8, 10, -1, 8'hF0, -1, '0, "R9");
    // One idle cycle: ready back, line high, word still offered.
    chk({s_ready, busy, txd} == 3'b101, "R9", "gap cycle", int'({s_ready, busy, txd}), 5);
    run_frame(8'hF0, 8, 8, -1, -1, '0, -1, '0, "R9");
    check_idle("R5", 8);
  endtask

  task automatic t_live_prescale();
    prescale = 16'd4;
    // Counter is 10 when prescale drops to 1, so the start bit ends after 11 cycles.
    run_frame(8'h96, 11, 8, -1, -1, '0, 10, 16'd1, "R8");
    check_idle("R8", 8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignore_busy();
    t_zero_prescale();
    t_back_to_back();
    t_live_prescale();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule